// File: doc/BRIEF.md
# Multi-Mode Configurable Lookup Table Cell

This block is a single programmable logic cell built around one 16-bit storage array. The array and a 2-bit mode field are loaded serially through a configuration shift chain. The chain's serial output lets many cells be linked into one long configuration path. Once loaded, the cell works in one of three personalities. As a truth table, the four select inputs pick one stored bit. As a tapped delay line, the data input shifts in on an enable and the four inputs pick the tap. As a 16x1 memory, it has a clocked write and a combinational read.

Configuration has priority over everything else. In any cycle where the configuration enable is high, the chain shifts and any user write or shift is discarded. Reset clears the storage and the mode, so a cell that has not been loaded reads as an all-zero truth table.

Top module: `cfg_lut_cell`

## Requirements
- R1: A synchronous active-high reset clears all 16 storage bits and the mode field. After reset, `lut_out` is 0 for every select value and `cfg_sout` is 0.
- R2: The chain is 18 bits long, with the mode at the far end. While `cfg_en` is high, each rising edge moves the whole chain one place and `cfg_sin` enters storage bit 0. Storage bit 15 moves into mode bit 0, and mode bit 0 moves into mode bit 1. The first of 18 bits shifted in becomes mode bit 1, the second becomes mode bit 0, and the rest fill storage bits 15 down to 0.
- R3: `cfg_sout` always shows mode bit 1, which is the bit the next configuration shift pushes out. Reloading a cell therefore presents its old chain contents on `cfg_sout` in the order mode[1], mode[0], storage[15] ... storage[0].
- R4: In logic mode (mode 00), `lut_out` equals storage bit `lut_sel`, where `lut_sel[0]` is the least significant address bit. The array does not change, whatever `user_we` and `user_din` do.
- R5: In shift mode (mode 01), each rising edge with `user_we` high and `cfg_en` low moves every storage bit up one position, and `user_din` enters bit 0. When `user_we` is low, the array holds.
- R6: In shift mode, `lut_out` is the tap at storage bit `lut_sel`.
- R7: In RAM mode (mode 10), a rising edge with `user_we` high and `cfg_en` low stores `user_din` at bit `lut_sel`. No other bit changes.
- R8: In RAM mode, the read is combinational. `lut_out` follows a change of `lut_sel` within the same cycle, with no clock edge in between.
- R9: When `cfg_en` and `user_we` are both high, only the configuration shift takes effect, in every mode.
- R10: Mode 11 is reserved and acts as logic mode. `user_we` has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration and user writes |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift the configuration chain this cycle |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (mode bit 1) |
| lut_sel | input | 4 | Logic inputs / tap select / memory address |
| user_din | input | 1 | Data for a shift or memory write |
| user_we | input | 1 | Shift enable (shift mode) or write enable (RAM mode) |
| lut_out | output | 1 | Selected storage bit |

## Verification
The hardest case to reach from the ports is a configuration shift and a user write or shift landing in the same cycle. Reaching it needs a cell already in a writable mode. The stimulus first loads RAM mode, then reloads the whole chain with `user_we` held high, `user_din` set to 1 and `lut_sel` moving every cycle. A full read sweep afterwards shows that the array matches the serial image exactly. The reload also checks the old image coming out on `cfg_sout` bit by bit. Shift-mode taps are compared after every enabled edge against a model of the delay line kept in the bench.

// File: rtl/cfg_lut_pkg.sv
package cfg_lut_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_SHIFT = 2'b01,
    MODE_RAM   = 2'b10,
    MODE_RSVD  = 2'b11
  } cell_mode_e;

  localparam int MODE_W = 2;

endpackage

// File: rtl/cfg_lut_mode_dec.sv
module cfg_lut_mode_dec
  import cfg_lut_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              cfg_en,
  input  logic              user_we,
  output logic              shift_en,
  output logic              wr_en
);

  cell_mode_e mode_e;

  always_comb begin
    mode_e   = cell_mode_e'(mode);
    shift_en = 1'b0;
    wr_en    = 1'b0;
    if (!cfg_en && user_we) begin
      unique case (mode_e)
        MODE_SHIFT: shift_en = 1'b1;
        MODE_RAM:   wr_en    = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_lut_store.sv
module cfg_lut_store
  import cfg_lut_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_sin,
  input  logic              shift_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  waddr,
  input  logic              din,
  output logic [DEPTH-1:0]  store_q,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      mode_q  <= '0;
    end else if (cfg_en) begin
      {mode_q, store_q} <= {mode_q[MODE_W-2:0], store_q, cfg_sin};
    end else if (shift_en) begin
      store_q <= {store_q[DEPTH-2:0], din};
    end else if (wr_en) begin
      store_q[waddr] <= din;
    end
  end

endmodule

// File: rtl/cfg_lut_mux.sv
module cfg_lut_mux #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] data,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int W = DEPTH >> (l + 1);
    logic [W-1:0] nodes;
    for (genvar n = 0; n < W; n++) begin : g_node
      if (l == 0) begin : g_leaf
        assign nodes[n] = sel[0] ? data[2*n+1] : data[2*n];
      end else begin : g_inner
        assign nodes[n] = sel[l] ? g_lvl[l-1].nodes[2*n+1] : g_lvl[l-1].nodes[2*n];
      end
    end
  end

  assign y = g_lvl[SEL_W-1].nodes[0];

endmodule

// File: rtl/cfg_lut_cell.sv
module cfg_lut_cell
  import cfg_lut_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_sin,
  output logic             cfg_sout,
  input  logic [SEL_W-1:0] lut_sel,
  input  logic             user_din,
  input  logic             user_we,
  output logic             lut_out
);

  localparam int DEPTH = 1 << SEL_W;

  logic [DEPTH-1:0]  store_q;
  logic [MODE_W-1:0] mode_q;
  logic              shift_en;
  logic              wr_en;

  cfg_lut_mode_dec u_dec (
    .mode     (mode_q),
    .cfg_en   (cfg_en),
    .user_we  (user_we),
    .shift_en (shift_en),
    .wr_en    (wr_en)
  );

  cfg_lut_store #(.SEL_W(SEL_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_sin  (cfg_sin),
    .shift_en (shift_en),
    .wr_en    (wr_en),
    .waddr    (lut_sel),
    .din      (user_din),
    .store_q  (store_q),
    .mode_q   (mode_q)
  );

  cfg_lut_mux #(.SEL_W(SEL_W)) u_mux (
    .data (store_q),
    .sel  (lut_sel),
    .y    (lut_out)
  );

  assign cfg_sout = mode_q[MODE_W-1];

endmodule

// File: rtl/cfg_lut_cell_chk.sv
module cfg_lut_cell_chk #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_sin,
  input logic             cfg_sout,
  input logic [SEL_W-1:0] lut_sel,
  input logic             user_din,
  input logic             user_we,
  input logic             lut_out,
  input logic [DEPTH-1:0] store_q,
  input logic [1:0]       mode_q
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (store_q == '0) && (mode_q == 2'b00) && !cfg_sout);

  // R2
  chain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> ({mode_q, store_q} == {$past(mode_q[0]), $past(store_q), $past(cfg_sin)}));

  // R3
  sout_moves_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_sout == $past(mode_q[0]));

  // R4
  logic_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !mode_q[1] && !mode_q[0]) |=> $stable(store_q));

  // R5
  delay_line_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && mode_q == 2'b01 && user_we) |=>
      store_q == {$past(store_q[DEPTH-2:0]), $past(user_din)});

  // R6
  tap_read_chk: assert property (@(posedge clk) disable iff (rst)
    lut_out == store_q[lut_sel]);

  // R7
  ram_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && mode_q == 2'b10 && user_we) |=> store_q[$past(lut_sel)] == $past(user_din));

  // R10
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && mode_q == 2'b11) |=> $stable(store_q));

endmodule

bind cfg_lut_cell cfg_lut_cell_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_sin  (cfg_sin),
  .cfg_sout (cfg_sout),
  .lut_sel  (lut_sel),
  .user_din (user_din),
  .user_we  (user_we),
  .lut_out  (lut_out),
  .store_q  (store_q),
  .mode_q   (mode_q)
);

// File: tb/test_cfg_lut_cell.sv
module test_cfg_lut_cell;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_en;
  logic       cfg_sin;
  logic       cfg_sout;
  logic [3:0] lut_sel;
  logic       user_din;
  logic       user_we;
  logic       lut_out;

  int tests = 0;
  int fails = 0;

  logic [15:0] exp_img;
  logic [1:0]  exp_mode;

  always #10 clk = ~clk;

  cfg_lut_cell i_cfg_lut_cell (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sin(cfg_sin), .cfg_sout(cfg_sout),
    .lut_sel(lut_sel), .user_din(user_din), .user_we(user_we), .lut_out(lut_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reads every tap combinationally in the low clock phase; nothing may write.
  task automatic sweep(input string req, input logic [15:0] img);
    for (int a = 0; a < 16; a++) begin
      lut_sel = a[3:0];
      #0.5;
      chk(req, {31'b0, lut_out}, {31'b0, img[a]});
    end
  endtask

  // Shift in mode then 16 storage bits (15 down to 0); checks old image on cfg_sout (R3).
  task automatic load(input logic [1:0] m, input logic [15:0] img, input logic hold_we);
    logic [17:0] old_chain;
    logic [17:0] new_chain;
    old_chain = {exp_mode, exp_img};
    new_chain = {m, img};
    for (int i = 17; i >= 0; i--) begin
      @(negedge clk);
      #1;
      chk("R3 cfg_sout", {31'b0, cfg_sout}, {31'b0, old_chain[i]});
      cfg_en  = 1'b1;
      cfg_sin = new_chain[i];
      if (hold_we) begin
        user_we  = 1'b1;
        user_din = 1'b1;
        lut_sel  = lut_sel + 4'd5;
      end
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    user_we = 1'b0;
    user_din = 1'b0;
    exp_img  = img;
    exp_mode = m;
  endtask

  task automatic user_cycle(input logic [3:0] sel, input logic d, input logic we);
    @(negedge clk);
    lut_sel  = sel;
    user_din = d;
    user_we  = we;
    @(negedge clk);
    user_we  = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_sin = 1'b0; lut_sel = '0; user_din = 1'b0; user_we = 1'b0;
    exp_img = '0; exp_mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    chk("R1 cfg_sout after reset", {31'b0, cfg_sout}, 32'd0);
    sweep("R1 reset image", 16'h0000);

    // R2 and R4: several truth tables
    load(2'b00, 16'hA5C3, 1'b0);
    sweep("R2 R4 logic A5C3", 16'hA5C3);
    load(2'b00, 16'h8001, 1'b0);
    sweep("R2 R4 logic 8001", 16'h8001);
    load(2'b00, 16'h6996, 1'b0);
    sweep("R2 R4 logic 6996", 16'h6996);
    for (int k = 0; k < 6; k++) user_cycle(k[3:0], k[0], 1'b1);
    sweep("R4 logic ignores we", 16'h6996);

    // R10: reserved mode behaves as logic
    load(2'b11, 16'h3C5A, 1'b0);
    sweep("R10 reserved read", 16'h3C5A);
    for (int k = 0; k < 6; k++) user_cycle(k[3:0], ~k[0], 1'b1);
    sweep("R10 reserved ignores we", 16'h3C5A);

    // R5 R6: delay line
    load(2'b01, 16'h1234, 1'b0);
    sweep("R6 shift taps initial", exp_img);
    for (int k = 0; k < 20; k++) begin
      logic d;
      d = ((k * 7) % 3) == 1;
      user_cycle(4'd0, d, 1'b1);
      exp_img = {exp_img[14:0], d};
      sweep("R5 R6 shift step", exp_img);
    end
    user_cycle(4'd3, 1'b1, 1'b0);
    sweep("R5 shift hold without we", exp_img);

    // R7 R8: memory
    load(2'b10, 16'h0000, 1'b0);
    for (int a = 0; a < 16; a++) begin
      logic d;
      d = ((a * 5 + 3) % 4) < 2;
      user_cycle(a[3:0], d, 1'b1);
      exp_img[a] = d;
      sweep("R7 single-bit write", exp_img);
    end
    // R8: address change seen without any clock edge
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      lut_sel = 4'(15 - a);
      #1;
      chk("R8 async read", {31'b0, lut_out}, {31'b0, exp_img[15-a]});
    end

    // R9: reload with user writes held high
    load(2'b10, 16'h4E21, 1'b1);
    sweep("R9 cfg wins over write", 16'h4E21);
    load(2'b01, 16'hB00F, 1'b1);
    sweep("R9 cfg wins over shift", 16'hB00F);

    // R1 again: reset after a load
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 cfg_sout after second reset", {31'b0, cfg_sout}, 32'd0);
    sweep("R1 second reset image", 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule